// File: doc/BRIEF.md
# Serial-Flash Partial Page Update Sequencer

This block is an SPI master that rewrites a few bytes inside one page of a page-organised serial flash without carrying the whole page across the serial link. A host presents a page number, a byte offset inside the page and up to a parameterised number of new bytes. The block then has the flash copy that page into its internal SRAM buffer, patches the buffer with the new bytes, and commits the buffer back to the page with a program command that erases first.

Before each of the three instructions, including the first, the block waits for the flash ready/busy pin to read high. Requests whose byte run is empty or would run past the end of the 528-byte page are refused at once. The serial clock runs at half the system clock.

Top module: `flash_page_updater`

## Requirements
- R1: After reset, spiCsN is 1, spiSck is 0, and busy, done and error are all 0.
- R2: A request with reqLen of 0, reqLen above MAX_BYTES, or reqOffset + reqLen above 528 gives a one-cycle error pulse in the cycle after it is presented. It causes no chip-select activity and leaves busy low.
- R3: An accepted request produces exactly three instructions in this order: opcode 0x53 (page to buffer), then 0x84 (buffer write), then 0x83 (buffer to page with erase).
- R4: Each instruction sends its opcode byte first and then three address bytes, most significant bit first. Together the address bytes form the 24-bit word {2'b00, page[11:0], offset[9:0]}.
- R5: The buffer-write instruction sends exactly reqLen data bytes after its address. Data byte k is taken from reqData[8k+7:8k]. The other two instructions carry no bytes after the address.
- R6: The SPI link uses mode 0. spiSck is low whenever spiCsN is high, and spiMosi does not change while spiSck is high.
- R7: Between instructions, spiCsN stays high for at least 4 system clocks, which is two SCK periods.
- R8: spiCsN never falls unless flashRdy was high in the cycle before.
- R9: busy goes high in the cycle after acceptance and stays high until completion. Completion comes when flashRdy reads high after the program step. done is then high for exactly one cycle, in the first cycle busy is low. Requests presented while busy are ignored.
- R10: After done, the flash page holds its previous contents, except that bytes offset to offset+reqLen-1 hold the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Update request strobe, taken when idle |
| reqPage | input | 12 | Target page number |
| reqOffset | input | 10 | First byte to replace inside the page |
| reqLen | input | 4 | Number of new bytes (1..MAX_BYTES) |
| reqData | input | 64 | New bytes, byte k in bits 8k+7:8k |
| flashRdy | input | 1 | Flash ready/busy pin, low while the flash is busy |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock, idle low |
| spiMosi | output | 1 | Serial data to the flash |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse when the update is complete |
| error | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench aims at the page edges. One request ends exactly at byte 527 of the last page, and another overruns by one byte; a sequencer with an off-by-one range check would either refuse the first or send traffic for the second. A flash stub holds ready/busy low for tens of cycles after the transfer and the program. A design that skipped the wait, or that raised done as soon as the program instruction was sent, would drop chip select while the flash was busy or would report completion early. A request presented mid-update, and a second patch to a page already patched, expose a design that restarts or loses bytes it should keep.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  localparam int PAGE_W     = 12;
  localparam int OFF_W      = 10;
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_PAD   = ADDR_BYTES * 8 - PAGE_W - OFF_W;
  localparam int MIN_GAP    = 4;

  typedef struct packed {
    logic       latchReq;
    logic       startFrame;
    logic       withData;
    logic [7:0] opcode;
  } fpuCtl_t;
endpackage

// File: rtl/fpu_ctrl.sv
module fpu_ctrl
  import fpu_pkg::*;
#(
  parameter int MAX_BYTES  = 8,
  parameter int LEN_W      = 4,
  parameter int PAGE_BYTES = 528,
  parameter int GAP_CLKS   = 4,
  parameter logic [7:0] OP_XFER  = 8'h53,
  parameter logic [7:0] OP_WRITE = 8'h84,
  parameter logic [7:0] OP_PROG  = 8'h83
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             flashRdy,
  input  logic             frameDone,
  input  logic             spiCsN,
  output fpuCtl_t          ctl,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam int GC_W = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_WAIT} state_t;
  state_t state;
  logic [1:0] step;      // instructions already sent
  logic [GC_W-1:0] gapCnt;
  logic reqOk, accept, launch, finish;

  always_comb begin
    reqOk  = (reqLen != '0) && (int'(reqLen) <= MAX_BYTES) &&
             (int'(reqOffset) + int'(reqLen) <= PAGE_BYTES);
    accept = (state == S_IDLE) && reqValid && reqOk;
    launch = (state == S_WAIT) && flashRdy && (step != 2'd3);
    finish = (state == S_WAIT) && flashRdy && (step == 2'd3);
    ctl.latchReq   = accept;
    ctl.startFrame = launch;
    ctl.withData   = (step == 2'd1);
    case (step)
      2'd0:    ctl.opcode = OP_XFER;
      2'd1:    ctl.opcode = OP_WRITE;
      default: ctl.opcode = OP_PROG;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      step   <= '0;
      gapCnt <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        S_IDLE: begin
          error <= reqValid && !reqOk;
          if (accept) begin
            state <= S_WAIT;
            step  <= '0;
            busy  <= 1'b1;
          end
        end
        S_SHIFT: if (frameDone) begin
          state  <= S_GAP;
          gapCnt <= '0;
        end
        S_GAP: begin
          if (int'(gapCnt) == GAP_CLKS - 1) state <= S_WAIT;
          else gapCnt <= gapCnt + 1'b1;
        end
        S_WAIT: begin
          if (launch) begin
            step  <= step + 1'b1;
            state <= S_SHIFT;
          end else if (finish) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  p_done_idle_r9:  assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  p_err_quiet_r2:  assert property (@(posedge clk) disable iff (!rstN) error |-> (!busy && spiCsN));
  p_cs_rdy_r8:     assert property (@(posedge clk) disable iff (!rstN) $fell(spiCsN) |-> $past(flashRdy));
endmodule

// File: rtl/fpu_datapath.sv
module fpu_datapath
  import fpu_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fpuCtl_t                ctl,
  input  logic [PAGE_W-1:0]      reqPage,
  input  logic [OFF_W-1:0]       reqOffset,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic [MAX_BYTES*8-1:0] reqData,
  output logic                   spiCsN,
  output logic                   spiSck,
  output logic                   spiMosi,
  output logic                   frameDone
);
  localparam int IDX_W = $clog2(MAX_BYTES + ADDR_BYTES + 2);

  logic [PAGE_W-1:0]      pageReg;
  logic [OFF_W-1:0]       offReg;
  logic [LEN_W-1:0]       lenReg;
  logic [MAX_BYTES*8-1:0] dataReg;
  logic [ADDR_BYTES*8-1:0] addrWord;
  logic [7:0]       shiftReg, nextByte;
  logic [2:0]       bitIdx;
  logic [IDX_W-1:0] byteIdx, lastIdx;
  logic             active;
  logic [2:0]       highCnt;

  assign addrWord = {{ADDR_PAD{1'b0}}, pageReg, offReg};
  assign spiMosi  = shiftReg[7];

  always_comb begin
    int k;
    k = int'(byteIdx) + 1;
    nextByte = '0;
    if (k <= ADDR_BYTES) nextByte = addrWord[8*(ADDR_BYTES-k) +: 8];
    else if (k - ADDR_BYTES - 1 < MAX_BYTES) nextByte = dataReg[8*(k-ADDR_BYTES-1) +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0; offReg <= '0; lenReg <= '0; dataReg <= '0;
    end else if (ctl.latchReq) begin
      pageReg <= reqPage; offReg <= reqOffset; lenReg <= reqLen; dataReg <= reqData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiCsN <= 1'b1; spiSck <= 1'b0; active <= 1'b0; frameDone <= 1'b0;
      shiftReg <= '0; bitIdx <= '0; byteIdx <= '0; lastIdx <= '0;
    end else begin
      frameDone <= 1'b0;
      if (ctl.startFrame) begin
        spiCsN   <= 1'b0;
        active   <= 1'b1;
        shiftReg <= ctl.opcode;
        bitIdx   <= 3'd7;
        byteIdx  <= '0;
        lastIdx  <= ctl.withData ? IDX_W'(ADDR_BYTES + int'(lenReg)) : IDX_W'(ADDR_BYTES);
      end else if (active && !spiSck) begin
        spiSck <= 1'b1;
      end else if (active) begin
        spiSck <= 1'b0;
        if (bitIdx != 3'd0) begin
          bitIdx   <= bitIdx - 1'b1;
          shiftReg <= {shiftReg[6:0], 1'b0};
        end else if (byteIdx == lastIdx) begin
          active    <= 1'b0;
          spiCsN    <= 1'b1;
          frameDone <= 1'b1;
        end else begin
          byteIdx  <= byteIdx + 1'b1;
          shiftReg <= nextByte;
          bitIdx   <= 3'd7;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= 3'd7;
    else if (!spiCsN) highCnt <= '0;
    else if (highCnt != 3'd7) highCnt <= highCnt + 1'b1;
  end

  p_sck_idle_r6:  assert property (@(posedge clk) disable iff (!rstN) spiCsN |-> !spiSck);
  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rstN) spiSck |-> $stable(spiMosi));
  p_cs_gap_r7:    assert property (@(posedge clk) disable iff (!rstN) $fell(spiCsN) |-> (int'(highCnt) >= MIN_GAP));
endmodule

// File: rtl/flash_page_updater.sv
module flash_page_updater
  import fpu_pkg::*;
#(
  parameter int MAX_BYTES  = 8,
  parameter int LEN_W      = $clog2(MAX_BYTES + 1),
  parameter int PAGE_BYTES = 528,
  parameter int GAP_CLKS   = 4,
  parameter logic [7:0] OP_XFER  = 8'h53,
  parameter logic [7:0] OP_WRITE = 8'h84,
  parameter logic [7:0] OP_PROG  = 8'h83
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [PAGE_W-1:0]      reqPage,
  input  logic [OFF_W-1:0]       reqOffset,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic [MAX_BYTES*8-1:0] reqData,
  input  logic                   flashRdy,
  output logic                   spiCsN,
  output logic                   spiSck,
  output logic                   spiMosi,
  output logic                   busy,
  output logic                   done,
  output logic                   error
);
  fpuCtl_t ctl;
  logic frameDone;

  fpu_ctrl #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .GAP_CLKS(GAP_CLKS),
    .OP_XFER(OP_XFER), .OP_WRITE(OP_WRITE), .OP_PROG(OP_PROG)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset), .reqLen(reqLen),
    .flashRdy(flashRdy), .frameDone(frameDone), .spiCsN(spiCsN), .ctl(ctl),
    .busy(busy), .done(done), .error(error)
  );

  fpu_datapath #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqPage(reqPage), .reqOffset(reqOffset),
    .reqLen(reqLen), .reqData(reqData), .spiCsN(spiCsN), .spiSck(spiSck),
    .spiMosi(spiMosi), .frameDone(frameDone)
  );
endmodule

// File: tb/tb_flash_page_updater.sv
`timescale 1ns/1ps
module tb_flash_page_updater;
  localparam int BUSY_XFER = 37;
  localparam int BUSY_PROG = 53;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [11:0] reqPage = '0;
  logic [9:0]  reqOffset = '0;
  logic [3:0]  reqLen = '0;
  logic [63:0] reqData = '0;
  logic flashRdy;
  logic spiCsN, spiSck, spiMosi, busy, done, error;

  always #5 clk = ~clk;

  flash_page_updater dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPage(reqPage), .reqOffset(reqOffset),
    .reqLen(reqLen), .reqData(reqData), .flashRdy(flashRdy), .spiCsN(spiCsN),
    .spiSck(spiSck), .spiMosi(spiMosi), .busy(busy), .done(done), .error(error)
  );

  int nCmp = 0, nBad = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural flash stub
  logic [7:0] mem [int];
  logic [7:0] sbuf [0:527];
  logic [7:0] rx [$];
  logic [7:0] curByte = '0;
  int busyLeft = 0, bitCnt = 0, highRun = 100, frameNo = 0, csFalls = 0;
  logic lastSck = 1'b0, lastCs = 1'b1, lastMosi = 1'b0, lastRdy = 1'b1;
  int expPage = 0, expOff = 0, expLen = 0;
  logic [63:0] expData = '0;

  assign flashRdy = (busyLeft == 0);

  function automatic logic [7:0] memRd(input int p, input int o);
    int key = p * 1024 + o;
    if (mem.exists(key)) return mem[key];
    return 8'((p * 7 + o * 3) & 255);
  endfunction

  task automatic endFrame();
    logic [7:0] expOp;
    int expSize, pg, of;
    logic [23:0] addr;
    frameNo++;
    expOp   = (frameNo == 1) ? 8'h53 : (frameNo == 2) ? 8'h84 : 8'h83;
    expSize = (frameNo == 2) ? 4 + expLen : 4;
    check(rx.size() == expSize, "R5 frame length", rx.size(), expSize);
    if (rx.size() < 4) return;
    check(rx[0] == expOp, "R3 opcode order", rx[0], expOp);
    addr = {rx[1], rx[2], rx[3]};
    check(addr == {2'b00, 12'(expPage), 10'(expOff)}, "R4 address bytes", addr, {2'b00, 12'(expPage), 10'(expOff)});
    pg = int'(addr[21:10]); of = int'(addr[9:0]);
    if (rx[0] == 8'h53) begin
      for (int i = 0; i < 528; i++) sbuf[i] = memRd(pg, i);
      busyLeft = BUSY_XFER;
    end else if (rx[0] == 8'h84) begin
      for (int k = 0; k < expLen && 4 + k < rx.size(); k++) begin
        check(rx[4+k] == expData[8*k +: 8], "R5 data byte", rx[4+k], expData[8*k +: 8]);
        if (of + k < 528) sbuf[of+k] = rx[4+k];
      end
    end else if (rx[0] == 8'h83) begin
      for (int i = 0; i < 528; i++) mem[pg * 1024 + i] = sbuf[i];
      busyLeft = BUSY_PROG;
    end
  endtask

  always @(negedge clk) begin
    if (busyLeft > 0) busyLeft--;
    if (rstN) begin
      if (spiSck) check(spiMosi == lastMosi, "R6 mosi held while sck high", spiMosi, lastMosi);
      if (spiCsN) check(!spiSck, "R6 sck idle low", spiSck, 0);
      if (!spiCsN && spiSck && !lastSck) begin
        curByte = {curByte[6:0], spiMosi};
        bitCnt++;
        if (bitCnt == 8) begin rx.push_back(curByte); bitCnt = 0; end
      end
      if (!spiCsN && lastCs) begin
        csFalls++;
        check(highRun >= 4, "R7 chip-select gap", highRun, 4);
        check(lastRdy, "R8 start only when ready", lastRdy, 1);
        rx.delete(); bitCnt = 0;
      end
      if (spiCsN && !lastCs) endFrame();
    end
    highRun  = spiCsN ? highRun + 1 : 0;
    lastSck  = spiSck; lastCs = spiCsN; lastMosi = spiMosi;
    lastRdy  = (busyLeft == 0);
  end

  task automatic doUpdate(input int p, input int o, input int n, input logic [63:0] d,
                          input bit poke);
    logic [7:0] img [0:527];
    int bad, waitCnt;
    bit seenDone;
    for (int i = 0; i < 528; i++) img[i] = memRd(p, i);
    for (int k = 0; k < n; k++) img[o+k] = d[8*k +: 8];
    expPage = p; expOff = o; expLen = n; expData = d; frameNo = 0;
    @(negedge clk);
    reqPage = 12'(p); reqOffset = 10'(o); reqLen = 4'(n); reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    seenDone = 0; waitCnt = 0;
    while (!seenDone && waitCnt < 4000) begin
      @(negedge clk);
      waitCnt++;
      if (poke && waitCnt == 50) begin
        reqPage = 12'd100; reqOffset = 10'd0; reqLen = 4'd1; reqData = 64'hEE; reqValid = 1'b1;
      end else reqValid = 1'b0;
      if (done) begin
        seenDone = 1;
        check(busy == 1'b0, "R9 busy low with done", busy, 0);
        check(frameNo == 3, "R3 three instructions before done", frameNo, 3);
        check(flashRdy, "R9 done only after program finishes", flashRdy, 1);
      end else if (busy !== 1'b1) begin
        check(0, "R9 busy held until done", busy, 1);
      end
    end
    check(seenDone, "R9 done reached", seenDone, 1);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", done, 0);
    bad = 0;
    for (int i = 0; i < 528; i++) if (memRd(p, i) != img[i]) bad++;
    check(bad == 0, "R10 page image after update", bad, 0);
  endtask

  task automatic badReq(input int o, input int n, input string why);
    int falls0 = csFalls;
    @(negedge clk);
    reqPage = 12'd3; reqOffset = 10'(o); reqLen = 4'(n); reqData = 64'h55; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(error == 1'b1, {"R2 error pulse ", why}, error, 1);
    check(busy == 1'b0, {"R2 busy stays low ", why}, busy, 0);
    @(negedge clk);
    check(error == 1'b0, {"R2 error one cycle ", why}, error, 0);
    repeat (30) @(negedge clk);
    check(csFalls == falls0, {"R2 no SPI traffic ", why}, csFalls, falls0);
  endtask

  initial begin
    int falls0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(spiCsN == 1'b1, "R1 reset csN", spiCsN, 1);
    check(spiSck == 1'b0, "R1 reset sck", spiSck, 0);
    check({busy, done, error} == 3'b000, "R1 reset status", {busy, done, error}, 0);

    doUpdate(5, 10, 3, 64'h0000_0000_00C3_B2A1, 0);
    doUpdate(4095, 525, 3, 64'h0000_0000_0011_2233, 0);
    doUpdate(0, 0, 8, 64'h8877_6655_4433_2211, 0);
    doUpdate(5, 12, 2, 64'h0000_0000_0000_F00D, 0);
    badReq(526, 3, "overrun");
    badReq(0, 0, "empty");
    badReq(0, 9, "too long");
    doUpdate(9, 100, 4, 64'h0000_0000_DEAD_BEEF, 1);
    falls0 = csFalls;
    repeat (40) @(negedge clk);
    check(csFalls == falls0, "R9 request while busy ignored", csFalls, falls0);
    check(memRd(100, 0) == 8'((100 * 7) & 255), "R9 ignored request left page untouched",
          memRd(100, 0), 8'((100 * 7) & 255));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule